// File: doc/BRIEF.md
# Dual Cascadable 8-bit Compare Timer

This block holds two 8-bit up-counters. Each counter runs from a shared free-running prescaler at one of seven rates. Each channel has two compare registers, A and B. A match on a compare can reset the counter, and each match or a counter wrap can raise a one-clock interrupt pulse when that pulse is enabled. Software programs the block through a small byte-wide register bus. Channel 0 also accepts 16-bit accesses that reach both channels' compare, count and clock-control bytes in one transfer.

Setting channel 0's clock source to the chaining code joins the two counters into one 16-bit counter. Channel 0 then holds the high byte and channel 1 the low byte. The pair counts at channel 1's rate and compares against the joined compare bytes. It clears and signals through channel 0's control byte, and channel 1's own interrupts stay silent.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, both counters read 0x00, all four compare bytes read 0xFF, and both control and clock-control bytes read 0x00. The status byte reads 0x00 on channel 0 and 0x10 on channel 1.
- R2: The register map is addressed by byte offset: bits 3:1 pick the register (0 control, 1 status, 2 compare A, 3 compare B, 4 count, 5 clock control) and bit 0 picks the channel. Control keeps bits 7:3, status keeps bits 5:0, and clock control keeps bits 7 and 4:0. All other bits read 0. Bit 4 of channel 1's status always reads 1. Read data appears one clock after the address.
- R3: Clock-control bits 2:0 select the count rate: codes 1..7 give one tick every 1, 2, 8, 32, 64, 1024 or 8192 clocks. With clear-on-A and compare A = N, compare-A pulses repeat every (N+1) times that divisor.
- R4: A counter holds its value when its rate code is 0, or when its source field (clock-control bits 4:3) is 0. Source codes 1 and 2 count from the prescaler.
- R5: Control bits 4:3 select the clear: 01 clears on a compare-A match, 10 clears on a compare-B match, and 00 and 11 never clear. On a tick where the count equals a compare value, that compare matches. A selected clear loads 0 instead of incrementing.
- R6: A compare-A or compare-B match drives its interrupt high for the clock after the tick. It does so only when its enable is set: bit 6 enables A and bit 7 enables B.
- R7: When the count increments past its all-ones value it wraps to 0. If control bit 5 is set, this pulses the overflow interrupt. Without a clear, the wrap repeats every 256 ticks.
- R8: With channel 0's source field at 3, the pair forms a 16-bit counter, channel 0 high. It ticks at channel 1's rate and compares against {ch0, ch1} compare bytes. It clears and raises interrupts through channel 0's control byte, and channel 1 raises no interrupts.
- R9: In 16-bit mode, the tick at 0xFFFF wraps the pair to 0x0000 and pulses channel 0's overflow if it is enabled.
- R10: A 16-bit access at an even offset of compare A, compare B, count or clock control writes or reads channel 0 in data bits 15:8 and channel 1 in bits 7:0. A 16-bit write at an odd offset or to control or status changes nothing. Such a 16-bit read returns 0.
- R11: A bus write to a count byte loads that value on the next edge and overrides the tick of that edge. In 16-bit mode, a write to either byte suppresses the pair's tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wide | input | 1 | Marks a 16-bit access |
| bus_wdata | input | 16 | Write data; byte accesses use bits 7:0 |
| bus_rdata | output | 16 | Registered read data for the current address |
| irq_cma | output | 2 | Compare-A pulse per channel |
| irq_cmb | output | 2 | Compare-B pulse per channel |
| irq_ovf | output | 2 | Overflow pulse per channel |

## Verification
The embedded properties assume that every bus input is driven to a known level on each clock. They also assume that the clock-source field of channel 0 is not flipped into or out of 16-bit mode while a pulse from the old mode is still in flight. The one-cycle-later checks on the silent channel-1 interrupts and the wrap value depend on that. The stimulus changes configuration only through single-cycle bus writes with the strobe low in between. It always programs the control and clock bytes before it rewrites a counter. Interval measurements start only after a first pulse has realigned the counter.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;
  localparam int CODE_N    = 8;
  localparam int MAX_SHIFT = 13;

  localparam logic [2:0] RG_CTRL = 3'd0;
  localparam logic [2:0] RG_STAT = 3'd1;
  localparam logic [2:0] RG_CMPA = 3'd2;
  localparam logic [2:0] RG_CMPB = 3'd3;
  localparam logic [2:0] RG_CNT  = 3'd4;
  localparam logic [2:0] RG_CLK  = 3'd5;

  localparam logic [7:0] CTRL_KEEP = 8'hF8;
  localparam logic [7:0] STAT_KEEP = 8'h3F;
  localparam logic [7:0] CLK_KEEP  = 8'h9F;
  localparam int         STAT_ADC_BIT = 4;

  localparam int CTL_OVF_EN = 5;
  localparam int CTL_A_EN   = 6;
  localparam int CTL_B_EN   = 7;

  localparam logic [1:0] CLR_ON_A = 2'b01;
  localparam logic [1:0] CLR_ON_B = 2'b10;
  localparam logic [1:0] SRC_CHAIN = 2'b11;

  // log2 of the clock divisor for each rate code (code 0 has no tick)
  function automatic int div_shift(input int code);
    case (code)
      1: return 0;
      2: return 1;
      3: return 3;
      4: return 5;
      5: return 6;
      6: return 10;
      7: return 13;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler
  import dual_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  output logic [CODE_N-1:0] tick_by_code
);
  logic [MAX_SHIFT-1:0] psc_q;

  always_ff @(posedge clk) begin
    if (rst) psc_q <= '0;
    else     psc_q <= psc_q + 1'b1;
  end

  for (genvar c = 0; c < CODE_N; c++) begin : g_rate
    if (c == 0) begin : g_off
      assign tick_by_code[c] = 1'b0;
    end else begin : g_on
      localparam int S = div_shift(c);
      if (S == 0) begin : g_full
        assign tick_by_code[c] = 1'b1;
      end else begin : g_div
        assign tick_by_code[c] = &psc_q[S-1:0];
      end
    end
  end

  // R3: slowest rate never ticks on two consecutive clocks
  p_slow_rate_gap_r3: assert property (@(posedge clk) disable iff (rst)
    tick_by_code[7] |=> !tick_by_code[7]);
  // R3: a slow tick coincides with every faster tick
  p_rates_nested_r3: assert property (@(posedge clk) disable iff (rst)
    tick_by_code[7] |-> (tick_by_code[6] && tick_by_code[3]));
endmodule

// File: rtl/dct_regs.sv
module dct_regs
  import dual_timer_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [3:0]           bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_wide,
  input  logic [2*CH_W-1:0]    bus_wdata,
  input  logic [1:0][CH_W-1:0] cnt_q,
  output logic [1:0][CH_W-1:0] ctrl_q,
  output logic [1:0][CH_W-1:0] cmpa_q,
  output logic [1:0][CH_W-1:0] cmpb_q,
  output logic [1:0][CH_W-1:0] clk_q,
  output logic [1:0]           cnt_wr,
  output logic [1:0][CH_W-1:0] cnt_wd,
  output logic [2*CH_W-1:0]    bus_rdata
);
  logic [1:0][CH_W-1:0] stat_q;
  logic [1:0][CH_W-1:0] rb;
  logic [2:0] idx;
  logic       ch;
  logic       wide_ok;
  logic       byte_wr;
  logic       wide_wr;

  assign idx     = bus_addr[3:1];
  assign ch      = bus_addr[0];
  assign wide_ok = bus_wide && !ch &&
                   (idx == RG_CMPA || idx == RG_CMPB || idx == RG_CNT || idx == RG_CLK);
  assign byte_wr = bus_wr && !bus_wide;
  assign wide_wr = bus_wr && wide_ok;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [CH_W-1:0] wbyte;
    logic            sel;
    assign wbyte = bus_wide ? bus_wdata[(2-c)*CH_W-1 -: CH_W] : bus_wdata[CH_W-1:0];
    assign sel   = (byte_wr && (ch == 1'(c))) || wide_wr;

    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_q[c] <= '0;
        stat_q[c] <= '0;
        cmpa_q[c] <= '1;
        cmpb_q[c] <= '1;
        clk_q[c]  <= '0;
      end else if (sel) begin
        case (idx)
          RG_CTRL: ctrl_q[c] <= wbyte & CTRL_KEEP;
          RG_STAT: stat_q[c] <= wbyte & STAT_KEEP;
          RG_CMPA: cmpa_q[c] <= wbyte;
          RG_CMPB: cmpb_q[c] <= wbyte;
          RG_CLK:  clk_q[c]  <= wbyte & CLK_KEEP;
          default: ;
        endcase
      end
    end

    assign cnt_wr[c] = sel && (idx == RG_CNT);
    assign cnt_wd[c] = wbyte;

    always_comb begin
      case (idx)
        RG_CTRL: rb[c] = ctrl_q[c];
        RG_STAT: begin
          rb[c] = stat_q[c];
          if (c == 1) rb[c][STAT_ADC_BIT] = 1'b1;
        end
        RG_CMPA: rb[c] = cmpa_q[c];
        RG_CMPB: rb[c] = cmpb_q[c];
        RG_CNT:  rb[c] = cnt_q[c];
        RG_CLK:  rb[c] = clk_q[c];
        default: rb[c] = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           bus_rdata <= '0;
    else if (bus_wide) bus_rdata <= wide_ok ? {rb[0], rb[1]} : '0;
    else               bus_rdata <= {{CH_W{1'b0}}, rb[ch]};
  end

  // R10: a 16-bit write at a channel-1 offset leaves every register alone
  p_wide_odd_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_wide && bus_addr[0]) |=>
      ($stable(ctrl_q) && $stable(stat_q) && $stable(cmpa_q) &&
       $stable(cmpb_q) && $stable(clk_q)));
  // R10: a 16-bit access to control or status never reaches the counters
  p_wide_ctrl_no_cnt_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_wide && (bus_addr[3:1] == RG_CTRL || bus_addr[3:1] == RG_STAT)) |-> (cnt_wr == 2'b00));
endmodule

// File: rtl/dct_core.sv
module dct_core
  import dual_timer_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0][CH_W-1:0] ctrl_q,
  input  logic [1:0][CH_W-1:0] cmpa_q,
  input  logic [1:0][CH_W-1:0] cmpb_q,
  input  logic [1:0][CH_W-1:0] clk_q,
  input  logic [CODE_N-1:0]    tick_by_code,
  input  logic [1:0]           cnt_wr,
  input  logic [1:0][CH_W-1:0] cnt_wd,
  output logic [1:0][CH_W-1:0] cnt_q,
  output logic [1:0]           irq_cma,
  output logic [1:0]           irq_cmb,
  output logic [1:0]           irq_ovf
);
  localparam int W2 = 2 * CH_W;

  logic                 chain;
  logic [1:0]           tk, ma, mb, clr, wrap;
  logic [1:0][CH_W-1:0] nxt;
  logic [W2-1:0]        c16, nxt16;
  logic                 ma16, mb16, clr16, wrap16;
  logic                 unused_bits;

  assign chain = (clk_q[0][4:3] == SRC_CHAIN);
  assign unused_bits = ^{ctrl_q[0][2:0], ctrl_q[1][2:0], clk_q[0][CH_W-1:5], clk_q[1][CH_W-1:5]};

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [1:0] src;
    assign src     = clk_q[c][4:3];
    assign tk[c]   = (src == 2'b01 || src == 2'b10) && tick_by_code[clk_q[c][2:0]];
    assign ma[c]   = (cnt_q[c] == cmpa_q[c]);
    assign mb[c]   = (cnt_q[c] == cmpb_q[c]);
    assign clr[c]  = (ctrl_q[c][4:3] == CLR_ON_A && ma[c]) ||
                     (ctrl_q[c][4:3] == CLR_ON_B && mb[c]);
    assign wrap[c] = !clr[c] && (cnt_q[c] == {CH_W{1'b1}});
    assign nxt[c]  = clr[c] ? '0 : cnt_q[c] + 1'b1;
  end

  assign c16    = {cnt_q[0], cnt_q[1]};
  assign ma16   = (c16 == {cmpa_q[0], cmpa_q[1]});
  assign mb16   = (c16 == {cmpb_q[0], cmpb_q[1]});
  assign clr16  = (ctrl_q[0][4:3] == CLR_ON_A && ma16) ||
                  (ctrl_q[0][4:3] == CLR_ON_B && mb16);
  assign wrap16 = !clr16 && (c16 == {W2{1'b1}});
  assign nxt16  = clr16 ? '0 : c16 + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      irq_cma <= '0;
      irq_cmb <= '0;
      irq_ovf <= '0;
    end else begin
      irq_cma <= '0;
      irq_cmb <= '0;
      irq_ovf <= '0;
      if (chain) begin
        if (cnt_wr[0]) cnt_q[0] <= cnt_wd[0];
        if (cnt_wr[1]) cnt_q[1] <= cnt_wd[1];
        if (!(|cnt_wr) && tk[1]) begin
          {cnt_q[0], cnt_q[1]} <= nxt16;
          irq_cma[0] <= ma16   && ctrl_q[0][CTL_A_EN];
          irq_cmb[0] <= mb16   && ctrl_q[0][CTL_B_EN];
          irq_ovf[0] <= wrap16 && ctrl_q[0][CTL_OVF_EN];
        end
      end else begin
        for (int c = 0; c < 2; c++) begin
          if (cnt_wr[c]) begin
            cnt_q[c] <= cnt_wd[c];
          end else if (tk[c]) begin
            cnt_q[c]   <= nxt[c];
            irq_cma[c] <= ma[c]   && ctrl_q[c][CTL_A_EN];
            irq_cmb[c] <= mb[c]   && ctrl_q[c][CTL_B_EN];
            irq_ovf[c] <= wrap[c] && ctrl_q[c][CTL_OVF_EN];
          end
        end
      end
    end
  end

  // R4: with no tick and no write the high/ch0 counter keeps its value
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!tk[0] && !cnt_wr[0] && !(chain && tk[1])) |=> $stable(cnt_q[0]));
  // R5: clear-on-A loads zero on a matching tick
  p_clear_on_a_r5: assert property (@(posedge clk) disable iff (rst)
    (!chain && tk[0] && !cnt_wr[0] && ctrl_q[0][4:3] == CLR_ON_A && cnt_q[0] == cmpa_q[0])
      |=> (cnt_q[0] == '0));
  // R6: a compare pulse is always preceded by a tick
  p_cma_after_tick_r6: assert property (@(posedge clk) disable iff (rst)
    irq_cma[0] |-> $past(tk[0] || tk[1]));
  // R7: an overflow pulse leaves the counter at zero
  p_ovf_leaves_zero_r7: assert property (@(posedge clk) disable iff (rst)
    irq_ovf[1] |-> (cnt_q[1] == '0));
  // R8: channel 1 stays silent while chained
  p_ch1_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    $past(chain) |-> (!irq_cma[1] && !irq_cmb[1] && !irq_ovf[1]));
  // R9: a chained overflow leaves the whole pair at zero
  p_wrap16_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_ovf[0] && $past(chain)) |-> (cnt_q[0] == '0 && cnt_q[1] == '0));
  // R11: a count write lands regardless of any tick
  p_write_wins_r11: assert property (@(posedge clk) disable iff (rst)
    cnt_wr[0] |=> (cnt_q[0] == $past(cnt_wd[0])));
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import dual_timer_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_wide,
  input  logic [2*CH_W-1:0] bus_wdata,
  output logic [2*CH_W-1:0] bus_rdata,
  output logic [1:0]        irq_cma,
  output logic [1:0]        irq_cmb,
  output logic [1:0]        irq_ovf
);
  logic [CODE_N-1:0]    tick_by_code;
  logic [1:0][CH_W-1:0] ctrl_q, cmpa_q, cmpb_q, clk_q, cnt_q, cnt_wd;
  logic [1:0]           cnt_wr;

  dct_prescaler u_psc (
    .clk          (clk),
    .rst          (rst),
    .tick_by_code (tick_by_code)
  );

  dct_regs #(.CH_W(CH_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wide  (bus_wide),
    .bus_wdata (bus_wdata),
    .cnt_q     (cnt_q),
    .ctrl_q    (ctrl_q),
    .cmpa_q    (cmpa_q),
    .cmpb_q    (cmpb_q),
    .clk_q     (clk_q),
    .cnt_wr    (cnt_wr),
    .cnt_wd    (cnt_wd),
    .bus_rdata (bus_rdata)
  );

  dct_core #(.CH_W(CH_W)) u_core (
    .clk          (clk),
    .rst          (rst),
    .ctrl_q       (ctrl_q),
    .cmpa_q       (cmpa_q),
    .cmpb_q       (cmpb_q),
    .clk_q        (clk_q),
    .tick_by_code (tick_by_code),
    .cnt_wr       (cnt_wr),
    .cnt_wd       (cnt_wd),
    .cnt_q        (cnt_q),
    .irq_cma      (irq_cma),
    .irq_cmb      (irq_cmb),
    .irq_ovf      (irq_ovf)
  );
endmodule

// File: tb/dual_cmp_timer_tb.sv
module dual_cmp_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_wide = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  irq_cma, irq_cmb, irq_ovf;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dual_cmp_timer u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_cma(irq_cma), .irq_cmb(irq_cmb), .irq_ovf(irq_ovf)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=%0d expected<190000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input bit w, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wide = w; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wide = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input bit w, output int d);
    @(negedge clk);
    bus_addr = a; bus_wide = w;
    @(negedge clk);
    d = int'(bus_rdata);
    bus_wide = 1'b0;
  endtask

  function automatic logic pick(input int s);
    case (s)
      0: return irq_cma[0];
      1: return irq_cmb[0];
      2: return irq_ovf[0];
      3: return irq_cma[1];
      4: return irq_cmb[1];
      default: return irq_ovf[1];
    endcase
  endfunction

  // cycles between two consecutive pulses on one output; -1 if none
  task automatic gap(input int s, input int limit, output int g);
    int n = 0;
    g = -1;
    while (n < limit && !pick(s)) begin @(negedge clk); n++; end
    if (!pick(s)) return;
    n = 0;
    do begin @(negedge clk); n++; end while (!pick(s) && n < limit);
    if (pick(s)) g = n;
  endtask

  task automatic quiet(input int s, input int len, output int seen);
    seen = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (pick(s)) seen = 1;
    end
  endtask

  initial begin
    int v, g, s;
    int divs[8] = '{0, 1, 2, 8, 32, 64, 1024, 8192};
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 / R2 reset readback
    for (int a = 0; a < 12; a++) begin
      int exp;
      rd(4'(a), 1'b0, v);
      case (a >> 1)
        2, 3:    exp = 8'hFF;
        1:       exp = (a & 1) ? 8'h10 : 8'h00;
        default: exp = 0;
      endcase
      check("R1 reset byte", v, exp);
    end
    // R2 field masks and forced status bit
    wr(4'd0, 1'b0, 16'h00FF);  rd(4'd0, 1'b0, v);  check("R2 ctrl mask", v, 8'hF8);
    wr(4'd10, 1'b0, 16'h00FF); rd(4'd10, 1'b0, v); check("R2 clkctl mask", v, 8'h9F);
    wr(4'd2, 1'b0, 16'h00FF);  rd(4'd2, 1'b0, v);  check("R2 status mask", v, 8'h3F);
    wr(4'd3, 1'b0, 16'h0000);  rd(4'd3, 1'b0, v);  check("R2 ch1 status bit4", v, 8'h10);
    wr(4'd10, 1'b0, 16'h0000); wr(4'd0, 1'b0, 16'h0000);

    // R10 wide accesses
    rd(4'd4, 1'b1, v); check("R10 wide cmpA reset", v, 16'hFFFF);
    wr(4'd6, 1'b1, 16'h1234); rd(4'd6, 1'b0, v); check("R10 wide high byte ch0", v, 8'h12);
    rd(4'd7, 1'b0, v); check("R10 wide low byte ch1", v, 8'h34);
    wr(4'd9, 1'b1, 16'h5566); rd(4'd8, 1'b1, v); check("R10 odd wide write ignored", v, 16'h0000);
    wr(4'd0, 1'b1, 16'hFFFF); rd(4'd0, 1'b0, v); check("R10 wide ctrl write ignored", v, 0);
    rd(4'd1, 1'b0, v); check("R10 wide ctrl write ignored ch1", v, 0);
    wr(4'd0, 1'b0, 16'h0048); rd(4'd0, 1'b1, v); check("R10 wide ctrl read zero", v, 0);
    wr(4'd6, 1'b1, 16'hFFFF);

    // R4 holds
    wr(4'd10, 1'b0, 16'h0008); wr(4'd8, 1'b0, 16'h0005);
    repeat (40) @(negedge clk);
    rd(4'd8, 1'b0, v); check("R4 rate code 0 holds", v, 5);
    wr(4'd10, 1'b0, 16'h0001);
    repeat (40) @(negedge clk);
    rd(4'd8, 1'b0, v); check("R4 source 0 holds", v, 5);

    // R3 / R5 / R6 divisor sweep, clear on A with compare 1
    wr(4'd4, 1'b0, 16'h0001);
    wr(4'd0, 1'b0, 16'h0048);
    for (int code = 1; code < 8; code++) begin
      wr(4'd10, 1'b0, 16'(8'h08 | code));
      wr(4'd8, 1'b0, 16'h0000);
      gap(0, 3 * divs[code] + 8, g);
      check($sformatf("R3 period code %0d", code), g, 2 * divs[code]);
    end
    // R6 disabled compare pulse
    wr(4'd10, 1'b0, 16'h0009); wr(4'd0, 1'b0, 16'h0008);
    quiet(0, 100, s); check("R6 compare A disabled", s, 0);
    // R7 overflow period, no clear
    wr(4'd0, 1'b0, 16'h0020);
    gap(2, 600, g); check("R7 overflow period", g, 256);
    quiet(0, 300, s); check("R6 compare A still disabled", s, 0);
    wr(4'd10, 1'b0, 16'h0000); wr(4'd0, 1'b0, 16'h0000);

    // R5 channel 1 clear on B, divisor 2, compare 5
    wr(4'd7, 1'b0, 16'h0005); wr(4'd1, 1'b0, 16'h0090);
    wr(4'd11, 1'b0, 16'h000A); wr(4'd9, 1'b0, 16'h0000);
    gap(4, 100, g); check("R5 clear on B period", g, 12);
    wr(4'd11, 1'b0, 16'h0009);
    wr(4'd1, 1'b0, 16'h0080); gap(4, 600, g); check("R5 select 00 no clear", g, 256);
    wr(4'd1, 1'b0, 16'h0098); gap(4, 600, g); check("R5 select 11 no clear", g, 256);
    wr(4'd1, 1'b0, 16'h0088); quiet(3, 600, s); check("R6 compare A ch1 disabled", s, 0);

    // R8 chained mode
    wr(4'd4, 1'b1, 16'h0123);
    wr(4'd1, 1'b0, 16'h00E0);
    wr(4'd0, 1'b0, 16'h0048);
    wr(4'd10, 1'b1, 16'h1809);
    wr(4'd8, 1'b1, 16'h0000);
    gap(0, 700, g); check("R8 16-bit clear-on-A period", g, 16'h124);
    quiet(3, 600, s); check("R8 ch1 compare A silent", s, 0);
    quiet(5, 600, s); check("R8 ch1 overflow silent", s, 0);
    // R9 / R11 chained wrap after a count write
    wr(4'd0, 1'b0, 16'h0020);
    wr(4'd8, 1'b1, 16'hFFF0);
    g = 0;
    do begin @(negedge clk); g++; end while (!irq_ovf[0] && g < 60);
    check("R9 R11 wrap 16 ticks after write", g, 16);
    wr(4'd10, 1'b1, 16'h1800);
    rd(4'd8, 1'b1, v);
    check("R9 pair small after wrap", (v < 16'h0010) ? 1 : 0, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule